// File: doc/BRIEF.md
# Oversampling Receive Bit-Clock Recovery with Edge Filter

This block recovers a bit clock and the data bits from a serial receive line. The line is sampled by a local clock running at 8, 16 or 32 times the bit rate. A phase counter runs once around per bit period and takes the data sample when it reaches the middle count. Transitions on the line pull the counter towards the real bit boundaries. The correction is at most one count per bit, so isolated jitter moves the sample point only slightly.

A two-bit edge filter chooses which transitions may move the phase: both directions, rising only, falling only, or none. Choosing none freezes the phase, so the bit period stays exactly at the nominal count. A direct mode samples the line on every local clock, with no phase tracking at all. An optional inversion flips the line polarity after synchronization and before edge detection and sampling. The outputs are one recovered bit and a strobe that is high for one cycle per bit. Line decoding, framing and carrier or clock-loss detection belong to the stages after this block.

Top module: `rx_dpll_edgesel`

## Requirements
- R1: While `rst_n` is low, `bit_valid` and `bit_data` are both 0.
- R2: With edges arriving on nominal bit boundaries, every transmitted bit is delivered exactly once, in order, sampled near the middle of its period, and strobes are exactly N cycles apart.
- R3: `ratio_sel` selects the mode: 2'b00 direct (1x), 2'b01 N=8, 2'b10 N=16, 2'b11 N=32.
- R4: `edge_sel` 2'b00 lets both rising and falling data transitions correct the phase.
- R5: `edge_sel` 2'b01 lets only rising transitions (of the possibly inverted data) correct the phase; falling ones are ignored.
- R6: `edge_sel` 2'b10 lets only falling transitions correct the phase; rising ones are ignored.
- R7: `edge_sel` 2'b11 freezes the phase: strobes stay exactly N cycles apart whatever the line does.
- R8: A qualifying transition seen in the upper half of the count (count > N/2) shortens the current bit by one cycle, so a fast line is tracked.
- R9: A qualifying transition seen at a count of 1 to N/2-1 lengthens the current bit by one cycle, so a slow line is tracked. A transition at count 0 or N/2 causes no correction.
- R10: At most one correction is made per bit period. A second qualifying transition in the same period has no effect.
- R11: In direct mode `bit_valid` is high on every cycle, `bit_data` is the line value three clocks late, and `edge_sel` has no effect.
- R12: With `rx_inv` = 1, the recovered bits are the complement of the line, and edge polarity is judged on the complemented data.
- R13: In the oversampled modes `bit_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Raw serial receive line |
| ratio_sel | input | 2 | Oversampling ratio: 00 direct, 01 x8, 10 x16, 11 x32 |
| edge_sel | input | 2 | Correcting transitions: 00 both, 01 rising, 10 falling, 11 none |
| rx_inv | input | 1 | 1 complements the line before edge detection and sampling |
| bit_data | output | 1 | Recovered data bit, valid with `bit_valid` |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |

## Verification
A wrong phase count or a wrong correction shows up in the spacing between strobes. The spacing moves to N+1, N-1 or some other value in the bit period where the error happens, so each correction can be counted at the ports. A drift in the sample point that goes uncorrected shows up later. After a few bit periods, which is about N/2 counts of accumulated slip, a sample lands in the wrong bit and the scoreboard sees a bad or shifted bit. A bad edge filter or a broken one-per-bit limit gives the wrong number of long or short intervals in the stimulus cases whose expected corrections are known.

// File: rtl/rx_dpll_edgesel.sv
module rx_dpll_edgesel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic [1:0] ratio_sel,
  input  logic [1:0] edge_sel,
  input  logic       rx_inv,
  output logic       bit_data,
  output logic       bit_valid
);
  localparam int CW = 5;

  logic          s1, s2, s3;
  logic [CW-1:0] cnt, mask, half;
  logic          adj_done;
  logic          d, dp, rise, fall, qual, early, late, oversample, wrap;
  logic [1:0]    step;
  logic [CW:0]   sum;

  assign oversample = (ratio_sel != 2'b00);

  always_comb begin
    case (ratio_sel)
      2'b01:   mask = 5'd7;
      2'b10:   mask = 5'd15;
      default: mask = 5'd31;
    endcase
  end
  assign half = (mask >> 1) + 5'd1;

  assign d    = s2 ^ rx_inv;
  assign dp   = s3 ^ rx_inv;
  assign rise = d & ~dp;
  assign fall = ~d & dp;

  always_comb begin
    case (edge_sel)
      2'b00:   qual = rise | fall;
      2'b01:   qual = rise;
      2'b10:   qual = fall;
      default: qual = 1'b0;
    endcase
  end

  assign early = qual && !adj_done && (cnt > half);
  assign late  = qual && !adj_done && (cnt != '0) && (cnt < half);
  assign step  = early ? 2'd2 : (late ? 2'd0 : 2'd1);
  assign sum   = {1'b0, cnt} + {{(CW-1){1'b0}}, step};
  assign wrap  = sum > {1'b0, mask};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      adj_done  <= 1'b0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else if (!oversample) begin
      cnt       <= '0;
      adj_done  <= 1'b0;
      bit_valid <= 1'b1;
      bit_data  <= d;
    end else begin
      cnt       <= sum[CW-1:0] & mask;
      adj_done  <= wrap ? 1'b0 : (adj_done | early | late);
      bit_valid <= (cnt == half);
      if (cnt == half) bit_data <= d;
    end
  end

  assert_single_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (oversample && bit_valid) |=> !bit_valid);

  assert_direct_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!oversample) |=> (bit_valid && cnt == '0));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ratio_sel) |-> ((cnt & ~mask) == '0));

  assert_mid_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (oversample && cnt == half) |=> (cnt == $past(half) + 5'd1));

  assert_frozen_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oversample && edge_sel == 2'b11) |=> (cnt == (($past(cnt) + 5'd1) & $past(mask))));

  assert_one_fix_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oversample && adj_done && cnt != '0) |=> (cnt == (($past(cnt) + 5'd1) & $past(mask))));
endmodule

// File: tb/sim_rx_dpll_edgesel.sv
module sim_rx_dpll_edgesel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b0;
  logic [1:0] ratio_sel = 2'b10;
  logic [1:0] edge_sel = 2'b00;
  logic       rx_inv = 1'b0;
  logic       bit_data, bit_valid;

  always #10 clk = ~clk;

  rx_dpll_edgesel u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .ratio_sel(ratio_sel),
    .edge_sel(edge_sel), .rx_inv(rx_inv), .bit_data(bit_data), .bit_valid(bit_valid)
  );

  int    checks = 0, errors = 0;
  int    cyc = 0, lastv = 0, cur_n = 16;
  bit    have_last = 1'b0;
  int    n_long = 0, n_short = 0, n_other = 0;
  string tag = "R2";
  bit    q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: strobe spacing and scoreboard compare
  always @(negedge clk) begin
    if (!rst_n) have_last = 1'b0;
    else if (bit_valid) begin
      if (have_last) begin
        if (cyc - lastv == cur_n) ;
        else if (cyc - lastv == cur_n + 1) n_long++;
        else if (cyc - lastv == cur_n - 1) n_short++;
        else n_other++;
      end
      lastv = cyc;
      have_last = 1'b1;
      if (q.size() > 0) begin
        bit e;
        e = q.pop_front();
        check(bit_data == e, tag, "recovered bit", bit_data, e);
      end
    end
  end

  task automatic run_case(input string t, input logic [1:0] rs, input logic [1:0] es,
                          input logic inv, input int off, input int p, input int nb,
                          input logic [63:0] pat, input bit push,
                          input int exp_long, input int exp_short);
    @(negedge clk);
    rst_n = 1'b0; rxd = 1'b0; ratio_sel = rs; edge_sel = es; rx_inv = inv; tag = t;
    cur_n = (rs == 2'b00) ? 1 : (4 << rs);
    q.delete(); n_long = 0; n_short = 0; n_other = 0;
    repeat (3) @(negedge clk);
    check({bit_valid, bit_data} == 2'b00, "R1", "outputs in reset", {bit_valid, bit_data}, 0);
    if (push) begin
      q.push_back(inv);
      if (rs == 2'b00) q.push_back(inv);
    end
    rst_n = 1'b1;
    if (rs != 2'b00) begin
      repeat (cur_n - 2 + off) @(posedge clk);
      @(negedge clk);
    end
    for (int i = 0; i < nb; i++) begin
      rxd = pat[i];
      if (push) q.push_back(pat[i] ^ inv);
      repeat (p) @(negedge clk);
    end
    repeat (cur_n + 4) @(negedge clk);
    check(q.size() == 0, t, "bits left undelivered", q.size(), 0);
    if (exp_long < 0) check(n_long >= 1, t, "lengthened bits", n_long, 1);
    else check(n_long == exp_long, t, "lengthened bits", n_long, exp_long);
    if (exp_short < 0) check(n_short >= 1, t, "shortened bits", n_short, 1);
    else check(n_short == exp_short, t, "shortened bits", n_short, exp_short);
    check(n_other == 0, "R13", "odd strobe spacing", n_other, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run_case("R2",  2'b10, 2'b00, 1'b0, 0, 16, 24, 64'h0000_0000_00B4_E2D1, 1'b1, 0, 0);
    run_case("R3",  2'b01, 2'b00, 1'b0, 0, 8,  16, 64'h0000_0000_0000_6C39, 1'b1, 0, 0);
    run_case("R9",  2'b01, 2'b00, 1'b1, 0, 9,  40, 64'h5555_5555_5555_5555, 1'b1, -1, 0);
    run_case("R8",  2'b11, 2'b00, 1'b0, 0, 31, 40, 64'h5555_5555_5555_5555, 1'b1, 0, -1);
    run_case("R7",  2'b10, 2'b11, 1'b0, 0, 17, 12, 64'h5555_5555_5555_5555, 1'b0, 0, 0);
    run_case("R5",  2'b10, 2'b01, 1'b0, 2, 16, 8,  64'h0000_0000_0000_00FF, 1'b1, 1, 0);
    run_case("R6",  2'b10, 2'b10, 1'b0, 2, 16, 8,  64'h0000_0000_0000_00FF, 1'b1, 0, 0);
    run_case("R6",  2'b10, 2'b10, 1'b0, 2, 16, 8,  64'h0000_0000_0000_000F, 1'b1, 1, 0);
    run_case("R4",  2'b10, 2'b00, 1'b0, 2, 16, 8,  64'h0000_0000_0000_000F, 1'b1, 2, 0);
    run_case("R10", 2'b10, 2'b00, 1'b0, 2, 1,  16, 64'h0000_0000_0000_0007, 1'b0, 1, 0);
    run_case("R11", 2'b00, 2'b01, 1'b1, 0, 1,  20, 64'h0000_0000_0009_B3A5, 1'b1, 0, 0);
    run_case("R12", 2'b10, 2'b00, 1'b1, 0, 16, 16, 64'h0000_0000_0000_C3A5, 1'b1, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule